// File: doc/BRIEF.md
# Debug register scan chain

This block is a 38-bit test-access data register that gives an external debugger read and write access to a small bank of on-chip debug registers. The TAP state machine lives elsewhere. It hands this block one-cycle capture, shift and update strobes, a select line and serial data in, and it takes serial data out. Each scan frame carries a 32-bit data word in bits 31:0, a 5-bit register address in bits 36:32 and a direction flag in bit 37, where 1 means write and 0 means read.

Writes complete at the update of the scan that carries them. Reads take two scans. The update of a read scan only records the address. The capture of the next scan then loads that register's contents into the data field, and the following shift moves them out. The bank holds debug control, debug status, vector catch, and communications control and data. It also holds a parameterised number of watch units, each with six value and mask registers. Capturing the communications data register consumes the pending word. Capturing the communications control register has no side effect, so a debugger ends a read burst by parking the address there. The contents of debug control and vector catch are also driven as ports toward the core.

Top module: `dbg_scan_chain`

## Requirements
- R1: Frame bits are shifted least significant bit first. A capture puts frame bit 0 on `tdo_o`. Each shift moves `tdi_i` into bit 37. A captured frame has bits 37:32 at zero.
- R2: An update with bit 37 at 0 records bits 36:32 as the read address and changes no register contents.
- R3: The capture after a read update returns the register at the recorded address in bits 31:0. After reset the recorded address is 0 (debug control).
- R4: An update with bit 37 at 1 writes bits 31:0 into the addressed register, truncated to its width. The unused upper bits read as zero.
- R5: Fixed register addresses and widths: debug control 0 (6 bits), debug status 1 (5 bits), vector catch 2 (8 bits), communications control 4 (6 bits), communications data 5 (32 bits).
- R6: Watch unit 0 occupies addresses 8..13 and watch unit 1 occupies 16..21. Within a unit, offsets 0..5 are address value, address mask, data value, data mask (all 32 bits), control value (9 bits) and control mask (8 bits).
- R7: A read of communications control returns the version parameter (default 6) in bits 31:28, and these bits cannot be written.
- R8: Writing communications data sets communications control bit 0 (word pending). Capturing communications data clears that bit. Capturing communications control changes nothing.
- R9: Addresses 3, 6, 7, 14, 15 and 22..31 read as zero, and writes to them have no effect.
- R10: Reset clears every register. `dbg_ctrl_o` and `vcatch_o` read zero after reset.
- R11: `dbg_ctrl_o` mirrors debug control, where bit 4 set selects monitor-mode debug and clear selects halting debug. `vcatch_o` mirrors vector catch.
- R12: Capture, shift and update strobes have no effect while `dr_sel_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Test clock |
| trst_ni | input | 1 | Active-low test reset |
| dr_sel_i | input | 1 | This data register is selected |
| capture_i | input | 1 | Capture-DR strobe |
| shift_i | input | 1 | Shift-DR strobe |
| update_i | input | 1 | Update-DR strobe |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (frame bit 0) |
| dbg_ctrl_o | output | 6 | Debug control contents |
| vcatch_o | output | 8 | Vector catch contents |

## Verification
The bench targets the one-scan read latency. A design that captured the address in the current frame, rather than the previously recorded one, would return every value one scan early. It sweeps all 32 addresses with writes and then reads. This catches narrow registers that fail to truncate, holes that keep data, and watch-unit offsets mapped in the wrong order. The pending-word sequence checks that only a capture of the data register clears bit 0 and that parking on the control register leaves it intact, and it checks that the version nibble survives an all-ones write. Scans with the select low must leave the bank untouched, or a later read shows the stray write.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int FRAME_W   = DATA_W + ADDR_W + 1;
    localparam int DIR_BIT   = FRAME_W - 1;
    localparam int VER_W     = 4;

    localparam int DCTRL_W   = 6;
    localparam int DSTAT_W   = 5;
    localparam int VCATCH_W  = 8;
    localparam int CCTRL_W   = 6;
    localparam int PEND_BIT  = 0;
    localparam int WCV_W     = 9;
    localparam int WCM_W     = 8;

    localparam int WU_REGS   = 6;
    localparam int WU_OFFS_W = 3;
    localparam int BLK_W     = ADDR_W - WU_OFFS_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t A_DCTRL  = 5'd0;
    localparam addr_t A_DSTAT  = 5'd1;
    localparam addr_t A_VCATCH = 5'd2;
    localparam addr_t A_CCTRL  = 5'd4;
    localparam addr_t A_CDATA  = 5'd5;
endpackage

// File: rtl/dbg_scan_shift.sv
module dbg_scan_shift
    import dbg_scan_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_en,
    input  logic               shift_en,
    input  logic               tdi,
    input  word_t              cap_data,
    output logic [FRAME_W-1:0] frame,
    output logic               tdo
);
    typedef struct packed {
        logic [FRAME_W-1:0] sr;
    } shift_st_t;

    shift_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cap_en) begin
            s_d.sr = {{(FRAME_W-DATA_W){1'b0}}, cap_data};
        end else if (shift_en) begin
            s_d.sr = {tdi, s_q.sr[FRAME_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign frame = s_q.sr;
    assign tdo   = s_q.sr[0];

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en && !cap_en |=> frame[FRAME_W-1] == $past(tdi)); // R1
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en && !cap_en |=> frame[FRAME_W-2:0] == $past(frame[FRAME_W-1:1])); // R1
    AST_CAP_HDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> frame[FRAME_W-1:DATA_W] == '0); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en && !shift_en |=> $stable(frame)); // R12
endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
    import dbg_scan_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WU_OFFS_W-1:0] wr_offs,
    input  word_t                wdata,
    input  logic [WU_OFFS_W-1:0] rd_offs,
    output word_t                rdata
);
    typedef struct packed {
        word_t              aval;
        word_t              amsk;
        word_t              dval;
        word_t              dmsk;
        logic [WCV_W-1:0]   cval;
        logic [WCM_W-1:0]   cmsk;
    } wu_st_t;

    wu_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (wr_offs)
                3'd0:    s_d.aval = wdata;
                3'd1:    s_d.amsk = wdata;
                3'd2:    s_d.dval = wdata;
                3'd3:    s_d.dmsk = wdata;
                3'd4:    s_d.cval = wdata[WCV_W-1:0];
                3'd5:    s_d.cmsk = wdata[WCM_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (rd_offs)
            3'd0:    rdata = s_q.aval;
            3'd1:    rdata = s_q.amsk;
            3'd2:    rdata = s_q.dval;
            3'd3:    rdata = s_q.dmsk;
            3'd4:    rdata[WCV_W-1:0] = s_q.cval;
            3'd5:    rdata[WCM_W-1:0] = s_q.cmsk;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_WU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(s_q)); // R2
    AST_WU_HOLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_offs >= WU_OFFS_W'(WU_REGS) |=> $stable(s_q)); // R9
endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
    import dbg_scan_pkg::*;
#(
    parameter int               NUM_WATCH = 2,
    parameter logic [VER_W-1:0] VERSION   = 4'd6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_upd,
    input  logic                cap_en,
    input  addr_t               upd_addr,
    input  word_t               wdata,
    output word_t               cap_data,
    output logic [DCTRL_W-1:0]  dbg_ctrl,
    output logic [VCATCH_W-1:0] vcatch
);
    typedef struct packed {
        addr_t               rd_addr;
        logic [DCTRL_W-1:0]  dctrl;
        logic [DSTAT_W-1:0]  dstat;
        logic [VCATCH_W-1:0] vcat;
        logic [CCTRL_W-1:0]  cctrl;
        word_t               cdata;
    } bank_st_t;

    bank_st_t s_d, s_q;

    word_t                wu_rd   [NUM_WATCH];
    logic [NUM_WATCH-1:0] wu_rhit;

    for (genvar u = 0; u < NUM_WATCH; u++) begin : g_wu
        localparam logic [BLK_W-1:0] BLK = BLK_W'(u + 1);
        logic wu_wr;
        assign wu_wr      = wr_en && (upd_addr[ADDR_W-1:WU_OFFS_W] == BLK);
        assign wu_rhit[u] = (s_q.rd_addr[ADDR_W-1:WU_OFFS_W] == BLK);
        dbg_watch_unit u_wu (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wu_wr),
            .wr_offs (upd_addr[WU_OFFS_W-1:0]),
            .wdata   (wdata),
            .rd_offs (s_q.rd_addr[WU_OFFS_W-1:0]),
            .rdata   (wu_rd[u])
        );
    end

    always_comb begin
        cap_data = '0;
        case (s_q.rd_addr)
            A_DCTRL:  cap_data[DCTRL_W-1:0]  = s_q.dctrl;
            A_DSTAT:  cap_data[DSTAT_W-1:0]  = s_q.dstat;
            A_VCATCH: cap_data[VCATCH_W-1:0] = s_q.vcat;
            A_CCTRL: begin
                cap_data[CCTRL_W-1:0]        = s_q.cctrl;
                cap_data[DATA_W-1 -: VER_W]  = VERSION;
            end
            A_CDATA:  cap_data = s_q.cdata;
            default: begin
                for (int u = 0; u < NUM_WATCH; u++) begin
                    if (wu_rhit[u]) cap_data = wu_rd[u];
                end
            end
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (cap_en && s_q.rd_addr == A_CDATA) begin
            s_d.cctrl[PEND_BIT] = 1'b0;
        end
        if (rd_upd) begin
            s_d.rd_addr = upd_addr;
        end
        if (wr_en) begin
            case (upd_addr)
                A_DCTRL:  s_d.dctrl = wdata[DCTRL_W-1:0];
                A_DSTAT:  s_d.dstat = wdata[DSTAT_W-1:0];
                A_VCATCH: s_d.vcat  = wdata[VCATCH_W-1:0];
                A_CCTRL:  s_d.cctrl = wdata[CCTRL_W-1:0];
                A_CDATA: begin
                    s_d.cdata           = wdata;
                    s_d.cctrl[PEND_BIT] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dbg_ctrl = s_q.dctrl;
    assign vcatch   = s_q.vcat;

    AST_RDADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_upd |=> $stable(s_q.rd_addr)); // R2
    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_upd && !wr_en && !cap_en |=> $stable({s_q.dctrl, s_q.dstat, s_q.vcat, s_q.cctrl, s_q.cdata})); // R2
    AST_VERSION_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rd_addr == A_CCTRL |-> cap_data[DATA_W-1 -: VER_W] == VERSION); // R7
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && upd_addr == A_CDATA |=> s_q.cctrl[PEND_BIT]); // R8
    AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en && !wr_en && s_q.rd_addr == A_CDATA |=> !s_q.cctrl[PEND_BIT]); // R8
    AST_CCTRL_CAP_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en && !wr_en && s_q.rd_addr == A_CCTRL |=> $stable(s_q.cctrl)); // R8
endmodule

// File: rtl/dbg_scan_chain.sv
module dbg_scan_chain
    import dbg_scan_pkg::*;
#(
    parameter int               NUM_WATCH = 2,
    parameter logic [VER_W-1:0] VERSION   = 4'd6
) (
    input  logic                tck_i,
    input  logic                trst_ni,
    input  logic                dr_sel_i,
    input  logic                capture_i,
    input  logic                shift_i,
    input  logic                update_i,
    input  logic                tdi_i,
    output logic                tdo_o,
    output logic [DCTRL_W-1:0]  dbg_ctrl_o,
    output logic [VCATCH_W-1:0] vcatch_o
);
    logic               cap_en, shift_en, upd_en, wr_en, rd_upd;
    logic [FRAME_W-1:0] frame;
    word_t              cap_data;

    assign cap_en   = dr_sel_i && capture_i;
    assign shift_en = dr_sel_i && shift_i;
    assign upd_en   = dr_sel_i && update_i;
    assign wr_en    = upd_en &&  frame[DIR_BIT];
    assign rd_upd   = upd_en && !frame[DIR_BIT];

    dbg_scan_shift u_shift (
        .clk      (tck_i),
        .rst_n    (trst_ni),
        .cap_en   (cap_en),
        .shift_en (shift_en),
        .tdi      (tdi_i),
        .cap_data (cap_data),
        .frame    (frame),
        .tdo      (tdo_o)
    );

    dbg_reg_bank #(
        .NUM_WATCH (NUM_WATCH),
        .VERSION   (VERSION)
    ) u_bank (
        .clk      (tck_i),
        .rst_n    (trst_ni),
        .wr_en    (wr_en),
        .rd_upd   (rd_upd),
        .cap_en   (cap_en),
        .upd_addr (frame[DIR_BIT-1:DATA_W]),
        .wdata    (frame[DATA_W-1:0]),
        .cap_data (cap_data),
        .dbg_ctrl (dbg_ctrl_o),
        .vcatch   (vcatch_o)
    );

    AST_DESELECT_HOLD: assert property (@(posedge tck_i) disable iff (!trst_ni)
        !dr_sel_i |=> $stable(dbg_ctrl_o) && $stable(vcatch_o)); // R12
endmodule

// File: tb/dbg_scan_chain_bench.sv
`timescale 1ns/1ps
module dbg_scan_chain_bench;
    localparam logic [3:0] VER = 4'd6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, cap = 1'b0, shf = 1'b0, upd = 1'b0, tdi = 1'b0;
    logic       tdo;
    logic [5:0] dctl;
    logic [7:0] vc;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    logic [31:0] mdl [32];
    int          rd_m = 0;

    always #2.5 clk = ~clk;

    dbg_scan_chain u_dbg_scan_chain (
        .tck_i      (clk),
        .trst_ni    (rst_n),
        .dr_sel_i   (sel),
        .capture_i  (cap),
        .shift_i    (shf),
        .update_i   (upd),
        .tdi_i      (tdi),
        .tdo_o      (tdo),
        .dbg_ctrl_o (dctl),
        .vcatch_o   (vc)
    );

    function automatic logic [31:0] wmask(int a);
        case (a)
            0, 4:                   return 32'h3F;
            1:                      return 32'h1F;
            2, 13, 21:              return 32'hFF;
            5, 8, 9, 10, 11,
            16, 17, 18, 19:         return 32'hFFFF_FFFF;
            12, 20:                 return 32'h1FF;
            default:                return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] mread(int a);
        if (a == 4) return {VER, mdl[4][27:0]};
        return mdl[a];
    endfunction

    function automatic string tag_of(int a);
        if (a == 4)                    return "R7";
        if (a == 5)                    return "R8";
        if (a < 8 && wmask(a) != 0)    return "R5";
        if (wmask(a) != 0)             return "R6";
        return "R9";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_scan(input bit sl, input bit dir, input int a,
                           input logic [31:0] d, input string tag);
        logic [37:0] fr, got;
        logic [31:0] exp;
        string       t;
        fr  = {dir, a[4:0], d};
        exp = mread(rd_m);
        t   = (tag == "") ? tag_of(rd_m) : tag;
        @(negedge clk); sel = sl; cap = 1'b1;
        @(negedge clk); cap = 1'b0; shf = 1'b1;
        for (int i = 0; i < 38; i++) begin
            tdi    = fr[i];
            got[i] = tdo;
            @(negedge clk);
        end
        shf = 1'b0; upd = 1'b1;
        @(negedge clk); upd = 1'b0; sel = 1'b0;
        if (sl) begin
            if (rd_m == 5) mdl[4][0] = 1'b0;
            if (dir) begin
                if (wmask(a) != 0) mdl[a] = d & wmask(a);
                if (a == 5) mdl[4][0] = 1'b1;
            end else begin
                rd_m = a;
            end
            check(t, got[31:0], exp);
            check("R1", {26'd0, got[37:32]}, 32'd0);
            check("R11", {26'd0, dctl}, {26'd0, mdl[0][5:0]});
            check("R11", {24'd0, vc}, {24'd0, mdl[2][7:0]});
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 32; a++) mdl[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state on the ports
        check("R10", {26'd0, dctl}, 32'd0);
        check("R10", {24'd0, vc}, 32'd0);
        // R3: address 0 is recorded after reset
        do_scan(1, 0, 0, 32'h0, "R3");

        // R4: all-ones writes truncate to register width
        foreach (mdl[a]) begin
            if (a < 3 || a == 12 || a == 13) do_scan(1, 1, a, 32'hFFFF_FFFF, "");
        end
        do_scan(1, 0, 0, 32'h0, "");
        do_scan(1, 0, 1, 32'h0, "R4");
        do_scan(1, 0, 2, 32'h0, "R4");
        do_scan(1, 0, 12, 32'h0, "R4");
        do_scan(1, 0, 13, 32'h0, "R4");
        do_scan(1, 0, 0, 32'h0, "R4");

        // R5 R6 R9: sweep every address with distinct patterns
        for (int a = 0; a < 32; a++)
            do_scan(1, 1, a, 32'h9E37_79B9 * (a + 1) ^ 32'h5A5A_0F0F, "");
        for (int a = 0; a < 32; a++)
            do_scan(1, 0, a, 32'h0, "");
        do_scan(1, 0, 0, 32'h0, "");

        // R2: read scans with nonzero data fields write nothing
        do_scan(1, 0, 2, 32'hDEAD_BEEF, "");
        do_scan(1, 0, 2, 32'h1234_5678, "R2");
        do_scan(1, 0, 8, 32'hFFFF_FFFF, "R2");
        do_scan(1, 0, 0, 32'h0, "R2");

        // R7: version bits survive an all-ones write
        do_scan(1, 1, 4, 32'hFFFF_FFFF, "");
        do_scan(1, 0, 4, 32'h0, "");
        do_scan(1, 0, 0, 32'h0, "R7");

        // R8: pending flag set by data write, cleared only by data capture
        do_scan(1, 1, 4, 32'h0, "");
        do_scan(1, 1, 5, 32'hCAFE_F00D, "");
        do_scan(1, 0, 4, 32'h0, "");
        do_scan(1, 0, 4, 32'h0, "R8");
        do_scan(1, 0, 5, 32'h0, "R8");
        do_scan(1, 0, 4, 32'h0, "R8");
        do_scan(1, 0, 0, 32'h0, "R8");

        // R11: monitor-mode bit appears on dbg_ctrl_o
        do_scan(1, 1, 0, 32'h10, "");
        check("R11", {31'd0, dctl[4]}, 32'd1);
        do_scan(1, 1, 0, 32'h0, "");
        check("R11", {31'd0, dctl[4]}, 32'd0);

        // R12: deselected scan must not write
        do_scan(1, 1, 2, 32'h3C, "");
        do_scan(0, 1, 2, 32'hA5, "");
        do_scan(0, 1, 0, 32'h3F, "");
        check("R12", {24'd0, vc}, 32'h3C);
        do_scan(1, 0, 2, 32'h0, "");
        do_scan(1, 0, 0, 32'h0, "R12");
        do_scan(1, 0, 0, 32'h0, "R12");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule